// File: doc/BRIEF.md
# Clamp-Balancing Burst Pattern Sequencer

This block sits in the digital core of an active-clamp flyback controller. It issues the low-side and high-side gate commands for the power stage. It has two jobs that help discharge an overcharged clamp capacitor toward the reflected output voltage. First, when switching moves from low-power operation back into burst operation, the first high-side pulse is stretched to 7/5 of its nominal length. Second, when the supply-undervoltage comparator flags a drooping bias supply while the feedback loop holds switching off, the block fires a rescue packet. The packet is a train of low-side pulses that charges the bootstrap supply, followed by one long high-side pulse.

All widths are programmable in clock cycles. The first rescue packet after reset, or after normal burst switching has resumed, carries more low-side pulses than any packet that follows it. A busy flag covers each packet from its trigger to the end of its high-side pulse. The analog comparators, dead-time insertion, gate drivers and the regulation loop are outside this block.

Top module: `clamp_balance_seq`

## Requirements
- R1: While `rst_n` is low, `pwml`, `pwmh` and `busy` are low. Reset clears the stretch tracking and arms the first-packet count of 9.
- R2: `pwml` and `pwmh` are never high in the same cycle. Each pulse is followed by `gap_width` low cycles on both outputs before the next pulse starts.
- R3: `mode` encoding: 0 = low-power, 1 = burst, 2 or 3 = hold. In low-power, the block repeats a low-side pulse of `lo_width` cycles followed by a gap, and `pwmh` never rises. In hold, no normal pulse starts.
- R4: In burst, pulses alternate high-side then low-side, starting with high-side. The first high-side pulse after any cycle spent in low-power lasts floor(`hi_width`*7/5) cycles. Every later one lasts `hi_width` cycles.
- R5: A rescue packet is triggered by a rising edge of `uv_flag` that is sampled while `mode` is hold and `busy` is low. `busy` is high from the next cycle, and the first low-side pulse starts one cycle after that.
- R6: A packet is N low-side pulses of `lo_width`, then one high-side pulse of `surv_hi_width`, with the normal gap after each pulse.
- R7: N is 9 for the first packet after reset or after any normal burst high-side pulse. N is 3 for every packet after a completed one.
- R8: `busy` falls in the cycle right after the packet's high-side pulse. A `uv_flag` rising edge while `busy` is high, or while `mode` is not hold, is ignored.
- R9: A width input of 0 is treated as 1 cycle.
- R10: If `mode` is low-power when the packet's high-side pulse is due, that pulse waits with `busy` held high, and fires once `mode` leaves low-power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Control-mode code (0 low-power, 1 burst, 2/3 hold) |
| uv_flag | input | 1 | Supply-undervoltage comparator output |
| lo_width | input | W | Low-side pulse width, cycles |
| hi_width | input | W | Nominal high-side pulse width, cycles |
| surv_hi_width | input | W | Rescue packet high-side width, cycles |
| gap_width | input | W | Idle cycles after each pulse |
| pwml | output | 1 | Low-side gate command |
| pwmh | output | 1 | High-side gate command |
| busy | output | 1 | Rescue packet in progress |

## Verification
All results are registered. A pulse decision sampled at edge k shows on the outputs after edge k, and a new pulse begins one edge after its gap's last cycle. `busy` rises one edge after the trigger and falls at the edge that ends the packet's high-side pulse. The bench runs a queue-based model that is updated at each rising edge. It compares the model against the outputs at the following falling edge, so every expected value is due in exactly the cycle these latencies give. Directed checks then measure the pulse lengths and count the low-side pulses inside `busy` windows.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

   // control-mode codes (decoded by the engine)
   typedef enum logic [1:0] {
      MODE_LOWPWR = 2'd0,
      MODE_BURST  = 2'd1,
      MODE_HOLD   = 2'd2,
      MODE_HOLD2  = 2'd3
   } cbs_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2,
      ST_GAP  = 2'd3
   } cbs_state_e;

   // slots in the width bundle
   localparam int unsigned WI_LO   = 0;
   localparam int unsigned WI_NOM  = 1;
   localparam int unsigned WI_SURV = 2;
   localparam int unsigned WI_GAP  = 3;
   localparam int unsigned WI_NUM  = 4;

endpackage

// File: rtl/cbs_width.sv
module cbs_width
   import cbs_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned STR_NUM   = 7,
   parameter int unsigned STR_DEN   = 5,
   parameter bit          STRETCH_EN = 1'b1,
   localparam int unsigned CW       = W + $clog2(STR_NUM + 1)
) (
   input  logic [WI_NUM-1:0][W-1:0]  raw_w,
   output logic [WI_NUM-1:0][CW-1:0] eff_w,
   output logic [CW-1:0]             stretch_w
);

   // R9: zero widths become one cycle
   for (genvar i = 0; i < WI_NUM; i++) begin : g_clamp
      always_comb begin
         if (raw_w[i] == '0) eff_w[i] = CW'(1);
         else                eff_w[i] = CW'(raw_w[i]);
      end
   end

   if (STRETCH_EN) begin : g_stretch
      logic [CW-1:0] prod;
      assign prod      = eff_w[WI_NOM] * CW'(STR_NUM);
      assign stretch_w = prod / CW'(STR_DEN);
   end else begin : g_nostretch
      assign stretch_w = eff_w[WI_NOM];
   end

endmodule

// File: rtl/cbs_trigger.sv
module cbs_trigger #(
   parameter int unsigned FIRST_CNT = 9,
   parameter int unsigned LATER_CNT = 3,
   localparam int unsigned LW       = $clog2(FIRST_CNT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uv_flag,
   input  logic in_hold,
   input  logic take_lo,
   input  logic surv_done,
   input  logic burst_resume,
   output logic busy,
   output logic left_zero
);

   logic          uv_q;
   logic          first_evt;
   logic [LW-1:0] lo_left;
   logic          trig;

   assign trig      = uv_flag && !uv_q && !busy && in_hold;
   assign left_zero = (lo_left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uv_q      <= 1'b0;
         busy      <= 1'b0;
         lo_left   <= '0;
         first_evt <= 1'b1;
      end else begin
         uv_q <= uv_flag;
         if (trig)           busy <= 1'b1;
         else if (surv_done) busy <= 1'b0;
         if (trig)         lo_left <= first_evt ? LW'(FIRST_CNT) : LW'(LATER_CNT);
         else if (take_lo) lo_left <= lo_left - LW'(1);
         if (burst_resume)   first_evt <= 1'b1;
         else if (surv_done) first_evt <= 1'b0;
      end
   end

   // R5
   trig_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(uv_flag) && !busy && in_hold) |=> busy);

   // R6
   lo_take_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_lo |-> (busy && !left_zero));

   // R8
   busy_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(surv_done));

endmodule

// File: rtl/cbs_engine.sv
module cbs_engine
   import cbs_pkg::*;
#(
   parameter int unsigned CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic          busy,
   input  logic          left_zero,
   input  logic [CW-1:0] lo_w,
   input  logic [CW-1:0] nom_w,
   input  logic [CW-1:0] str_w,
   input  logic [CW-1:0] surv_w,
   input  logic [CW-1:0] gap_w,
   output logic          pwml,
   output logic          pwmh,
   output logic          take_lo,
   output logic          surv_done,
   output logic          burst_resume
);

   cbs_state_e    st, st_n;
   logic [CW-1:0] cnt, cnt_n;
   logic          surv_hi, surv_hi_n;
   logic          next_hi, next_hi_n;
   logic          stretch, stretch_n;
   logic          dp;
   logic          is_lowpwr, is_burst;

   assign is_lowpwr = (mode == MODE_LOWPWR);
   assign is_burst  = (mode == MODE_BURST);
   assign dp        = (st == ST_IDLE) || (st == ST_GAP && cnt == CW'(1));

   always_comb begin
      st_n         = st;
      cnt_n        = cnt;
      surv_hi_n    = surv_hi;
      next_hi_n    = next_hi;
      stretch_n    = stretch | is_lowpwr;
      take_lo      = 1'b0;
      surv_done    = 1'b0;
      burst_resume = 1'b0;
      unique case (st)
         ST_LO, ST_HI: begin
            if (cnt == CW'(1)) begin
               st_n  = ST_GAP;
               cnt_n = gap_w;
               if (st == ST_HI && surv_hi) begin
                  surv_done = 1'b1;
                  surv_hi_n = 1'b0;
               end
            end else begin
               cnt_n = cnt - CW'(1);
            end
         end
         ST_GAP: begin
            if (cnt != CW'(1)) cnt_n = cnt - CW'(1);
         end
         default: ;
      endcase
      if (dp) begin
         st_n = ST_IDLE;
         if (busy && !left_zero) begin
            st_n    = ST_LO;
            cnt_n   = lo_w;
            take_lo = 1'b1;
         end else if (busy) begin
            if (!is_lowpwr) begin
               st_n      = ST_HI;
               cnt_n     = surv_w;
               surv_hi_n = 1'b1;
            end
         end else if (is_burst) begin
            if (next_hi) begin
               st_n         = ST_HI;
               cnt_n        = stretch ? str_w : nom_w;
               stretch_n    = 1'b0;
               next_hi_n    = 1'b0;
               burst_resume = 1'b1;
            end else begin
               st_n      = ST_LO;
               cnt_n     = lo_w;
               next_hi_n = 1'b1;
            end
         end else if (is_lowpwr) begin
            st_n      = ST_LO;
            cnt_n     = lo_w;
            next_hi_n = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         surv_hi <= 1'b0;
         next_hi <= 1'b1;
         stretch <= 1'b0;
      end else begin
         st      <= st_n;
         cnt     <= cnt_n;
         surv_hi <= surv_hi_n;
         next_hi <= next_hi_n;
         stretch <= stretch_n;
      end
   end

   assign pwml = (st == ST_LO);
   assign pwmh = (st == ST_HI);

   // R2
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwml && pwmh));

   // R2
   hi_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwmh |=> !pwml);

   // R2
   lo_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwml |=> !pwmh);

   // R3
   no_hi_in_lowpwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwmh) |-> ($past(mode) != MODE_LOWPWR));

endmodule

// File: rtl/clamp_balance_seq.sv
module clamp_balance_seq
   import cbs_pkg::*;
#(
   parameter int unsigned W          = 8,
   parameter int unsigned FIRST_CNT  = 9,
   parameter int unsigned LATER_CNT  = 3,
   parameter int unsigned STR_NUM    = 7,
   parameter int unsigned STR_DEN    = 5,
   parameter bit          STRETCH_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   mode,
   input  logic         uv_flag,
   input  logic [W-1:0] lo_width,
   input  logic [W-1:0] hi_width,
   input  logic [W-1:0] surv_hi_width,
   input  logic [W-1:0] gap_width,
   output logic         pwml,
   output logic         pwmh,
   output logic         busy
);

   localparam int unsigned CW = W + $clog2(STR_NUM + 1);

   if (W < 2) begin : g_bad_w
      $error("clamp_balance_seq: W must be at least 2");
   end
   if (LATER_CNT < 1 || FIRST_CNT < LATER_CNT) begin : g_bad_cnt
      $error("clamp_balance_seq: need 1 <= LATER_CNT <= FIRST_CNT");
   end
   if (STR_DEN < 1 || STR_NUM < STR_DEN) begin : g_bad_ratio
      $error("clamp_balance_seq: stretch ratio must be >= 1");
   end

   logic [WI_NUM-1:0][W-1:0]  raw_w;
   logic [WI_NUM-1:0][CW-1:0] eff_w;
   logic [CW-1:0]             str_w;
   logic                      take_lo, surv_done, burst_resume, left_zero;
   logic                      in_hold;

   assign raw_w[WI_LO]   = lo_width;
   assign raw_w[WI_NOM]  = hi_width;
   assign raw_w[WI_SURV] = surv_hi_width;
   assign raw_w[WI_GAP]  = gap_width;
   assign in_hold        = (mode == MODE_HOLD) || (mode == MODE_HOLD2);

   cbs_width #(
      .W(W), .STR_NUM(STR_NUM), .STR_DEN(STR_DEN), .STRETCH_EN(STRETCH_EN)
   ) width_i (
      .raw_w     (raw_w),
      .eff_w     (eff_w),
      .stretch_w (str_w)
   );

   cbs_trigger #(
      .FIRST_CNT(FIRST_CNT), .LATER_CNT(LATER_CNT)
   ) trig_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .uv_flag      (uv_flag),
      .in_hold      (in_hold),
      .take_lo      (take_lo),
      .surv_done    (surv_done),
      .burst_resume (burst_resume),
      .busy         (busy),
      .left_zero    (left_zero)
   );

   cbs_engine #(.CW(CW)) eng_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode         (mode),
      .busy         (busy),
      .left_zero    (left_zero),
      .lo_w         (eff_w[WI_LO]),
      .nom_w        (eff_w[WI_NOM]),
      .str_w        (str_w),
      .surv_w       (eff_w[WI_SURV]),
      .gap_w        (eff_w[WI_GAP]),
      .pwml         (pwml),
      .pwmh         (pwmh),
      .take_lo      (take_lo),
      .surv_done    (surv_done),
      .burst_resume (burst_resume)
   );

   // R8
   busy_ends_with_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(pwmh) && !pwmh));

   // R10
   hi_needs_busy_or_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwmh) && $past(busy)) |-> $past(left_zero));

endmodule

// File: tb/clamp_balance_seq_tb_top.sv
`timescale 1ns/1ps
module clamp_balance_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd2;
   logic       uv = 1'b0;
   logic [7:0] lo_r = 8'd3, nom_r = 8'd5, surv_r = 8'd12, gap_r = 8'd2;
   logic       pwml, pwmh, busy;

   always #4 clk = ~clk;

   clamp_balance_seq dut_i (
      .clk(clk), .rst_n(rst_n), .mode(mode), .uv_flag(uv),
      .lo_width(lo_r), .hi_width(nom_r), .surv_hi_width(surv_r), .gap_width(gap_r),
      .pwml(pwml), .pwmh(pwmh), .busy(busy)
   );

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int  q[$];
   bit  m_busy = 0, m_first = 1, m_stretch = 0, m_nexthi = 1, uv_prev = 0;
   int  m_left = 0;
   bit  exp_l = 0, exp_h = 0;

   function automatic int eff(input logic [7:0] w);
      return (w == 0) ? 1 : int'(w);
   endfunction

   function automatic void push_pulse(input int code, input int w, input bit clr);
      for (int i = 0; i < w; i++) q.push_back(code);
      for (int i = 0; i < eff(gap_r); i++) q.push_back((i == 0 && clr) ? 4 : 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         m_busy = 0; m_first = 1; m_stretch = 0; m_nexthi = 1; uv_prev = 0;
         m_left = 0; exp_l = 0; exp_h = 0;
      end else begin
         bit old_busy, old_first;
         int e;
         old_busy  = m_busy;
         old_first = m_first;
         if (q.size() == 0) begin
            if (m_busy && m_left > 0) begin
               push_pulse(1, eff(lo_r), 0);
               m_left--;
            end else if (m_busy) begin
               if (mode != 2'd0) push_pulse(2, eff(surv_r), 1);
            end else if (mode == 2'd1) begin
               if (m_nexthi) begin
                  push_pulse(2, m_stretch ? (eff(nom_r) * 7) / 5 : eff(nom_r), 0);
                  m_stretch = 0; m_first = 1; m_nexthi = 0;
               end else begin
                  push_pulse(1, eff(lo_r), 0);
                  m_nexthi = 1;
               end
            end else if (mode == 2'd0) begin
               push_pulse(1, eff(lo_r), 0);
               m_nexthi = 1;
            end
         end
         e = (q.size() > 0) ? q.pop_front() : 0;
         exp_l = e[0];
         exp_h = e[1];
         if (e[2]) begin m_busy = 0; m_first = 0; end
         if (mode == 2'd0) m_stretch = 1;
         if (uv && !uv_prev && !old_busy && mode >= 2'd2) begin
            m_busy = 1;
            m_left = old_first ? 9 : 3;
         end
         uv_prev = uv;
      end
   end

   // ---------------- monitors ----------------
   int hi_lens[$];
   int hi_run = 0, lo_run = 0, lo_last = 0;
   int lo_in_busy = 0, hi_count = 0, busy_count = 0;
   bit prev_l = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         chk({pwml, pwmh, busy} == {exp_l, exp_h, m_busy}, cur_req,
             int'({pwml, pwmh, busy}), int'({exp_l, exp_h, m_busy}));
         chk(!(pwml && pwmh), "R2", int'({pwml, pwmh}), 0);
         if (pwmh) hi_run++;
         else if (hi_run > 0) begin hi_lens.push_back(hi_run); hi_run = 0; end
         if (pwml) lo_run++;
         else if (lo_run > 0) begin lo_last = lo_run; lo_run = 0; end
         if (pwml && !prev_l && busy) lo_in_busy++;
         if (pwmh && !prev_l) hi_count += 0;
         if ($rose(pwmh)) hi_count++;
         if (busy) busy_count++;
         prev_l = pwml;
      end
   end

   task automatic pulse_uv();
      uv = 1'b1;
      repeat (3) @(negedge clk);
      uv = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
      repeat (20) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (4) @(negedge clk);
      chk({pwml, pwmh, busy} == 3'b000, "R1", int'({pwml, pwmh, busy}), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk({pwml, pwmh, busy} == 3'b000, "R1", int'({pwml, pwmh, busy}), 0);

      // R3: low-power, low-side only
      cur_req = "R3"; hi_count = 0;
      mode = 2'd0;
      repeat (40) @(negedge clk);
      chk(hi_count == 0, "R3", hi_count, 0);
      chk(lo_last == 3, "R3", lo_last, 3);

      // R4: stretched first high-side pulse
      cur_req = "R4"; hi_lens.delete();
      mode = 2'd1;
      repeat (60) @(negedge clk);
      chk(hi_lens.size() >= 2 && hi_lens[0] == 7, "R4", hi_lens.size() > 0 ? hi_lens[0] : -1, 7);
      chk(hi_lens.size() >= 2 && hi_lens[1] == 5, "R4", hi_lens.size() > 1 ? hi_lens[1] : -1, 5);
      mode = 2'd2;
      repeat (30) @(negedge clk);

      // R5/R6/R7: first packet after burst switching has 9 low-side pulses
      cur_req = "R7"; hi_lens.delete(); lo_in_busy = 0;
      pulse_uv();
      chk(busy == 1'b1, "R5", busy, 1);
      wait_idle();
      chk(lo_in_busy == 9, "R7", lo_in_busy, 9);
      chk(hi_lens.size() == 1 && hi_lens[0] == 12, "R6", hi_lens.size() > 0 ? hi_lens[0] : -1, 12);

      // R7/R8: later packet has 3, re-trigger while busy ignored
      cur_req = "R8"; lo_in_busy = 0; hi_lens.delete();
      pulse_uv();
      repeat (3) @(negedge clk);
      pulse_uv();
      wait_idle();
      chk(lo_in_busy == 3, "R7", lo_in_busy, 3);
      chk(hi_lens.size() == 1, "R8", hi_lens.size(), 1);

      // R8: trigger outside hold ignored
      busy_count = 0;
      mode = 2'd1;
      repeat (5) @(negedge clk);
      pulse_uv();
      repeat (30) @(negedge clk);
      chk(busy_count == 0, "R8", busy_count, 0);
      mode = 2'd2;
      repeat (30) @(negedge clk);

      // R7: count re-armed to 9 after burst resumed
      cur_req = "R7"; lo_in_busy = 0;
      pulse_uv();
      wait_idle();
      chk(lo_in_busy == 9, "R7", lo_in_busy, 9);

      // R9: zero widths, R4 with a larger nominal
      cur_req = "R9";
      lo_r = 8'd0; gap_r = 8'd0; nom_r = 8'd10;
      repeat (2) @(negedge clk);
      mode = 2'd0;
      repeat (20) @(negedge clk);
      chk(lo_last == 1, "R9", lo_last, 1);
      hi_lens.delete();
      mode = 2'd1;
      repeat (60) @(negedge clk);
      chk(hi_lens.size() >= 2 && hi_lens[0] == 14, "R4", hi_lens.size() > 0 ? hi_lens[0] : -1, 14);
      chk(hi_lens.size() >= 2 && hi_lens[1] == 10, "R4", hi_lens.size() > 1 ? hi_lens[1] : -1, 10);
      mode = 2'd2;
      repeat (30) @(negedge clk);

      // R10: packet high-side pulse deferred in low-power
      cur_req = "R10";
      lo_r = 8'd2; gap_r = 8'd1; surv_r = 8'd6;
      repeat (2) @(negedge clk);
      hi_lens.delete(); hi_count = 0;
      pulse_uv();
      mode = 2'd0;
      repeat (80) @(negedge clk);
      chk(hi_count == 0, "R10", hi_count, 0);
      chk(busy == 1'b1, "R10", busy, 1);
      mode = 2'd2;
      wait_idle();
      chk(hi_lens.size() == 1 && hi_lens[0] == 6, "R10", hi_lens.size() > 0 ? hi_lens[0] : -1, 6);
      chk(busy == 1'b0, "R8", busy, 0);

      finish_run();
   end

endmodule